// File: doc/BRIEF.md
# TLB Search List Configuration Checker

This block handles the commands that write and read the per-CPU TLB probe lists. A probe list is an ordered array of 16-bit entries. Each entry tells the probe sequencer which context register and which page size to try next. There are four live lists, one for each combination of privileged or user mode with instruction or data access. The probe sequencer reads them through a combinational read port.

A write command names the mode and a 2-bit access selector, then streams exactly `ENTRIES` entries, one per cycle. Each entry is checked against the capability inputs as it arrives: the supported page-size mask, the number of shared contexts, and whether the mode is unified. Entries are collected in a shadow buffer. The live lists change only when the whole command is legal, so a rejected write never leaves a half-written list.

A read command streams one live list back, entry by entry. A status pulse (`done` with `ok`) closes every command.

Top module: `srch_cfg_check`

## Requirements
- R1: After reset, `done` and `rd_valid` are low and every entry of all four live lists reads as zero.
- R2: A command whose access selector is 0 finishes with `ok` low. This applies to both writes and reads.
- R3: A read with selector 2'b11 finishes with `ok` low. A read with selector 2'b10 (instruction) or 2'b01 (data) gives `ENTRIES` beats on `rd_valid`/`rd_data` in index order from the chosen live list, with `ok` high on the last beat. A read never changes a live list.
- R4: When the commanded mode is unified (`uni_priv` or `uni_user` high), a write must use selector 2'b11, or it finishes with `ok` low.
- R5: Entry layout: bit 15 is enable, bits 10:7 are the context index, and bits 2:0 are the size code. Other bits are ignored. An enabled entry whose size code has a zero bit in `size_mask` rejects the write.
- R6: An enabled entry whose context index is larger than `shared_cnt` rejects the write. With `shared_cnt` at 0, any nonzero context is rejected.
- R7: In a privileged write, an enabled entry with a nonzero context index rejects the write, whatever `shared_cnt` is.
- R8: Entries at and after the first entry with enable clear are not checked. On an accepted write they are still stored exactly as given.
- R9: A rejected write leaves all live lists unchanged. An accepted write replaces the instruction list of its mode when selector bit 1 is set, and the data list when bit 0 is set. Selector 2'b11 writes the same contents to both.
- R10: A write takes exactly `ENTRIES` entries on cycles with `ent_valid` high. `done` is high for one cycle, in the cycle after the clock edge that accepts the last entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| size_mask | input | 8 | Supported page-size codes, one bit per code |
| shared_cnt | input | 4 | Number of shared contexts supported |
| uni_priv | input | 1 | Privileged instruction and data lists are unified |
| uni_user | input | 1 | User instruction and data lists are unified |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_set | input | 1 | 1 = write list, 0 = read list |
| cmd_priv | input | 1 | 1 = privileged list, 0 = user list |
| cmd_flags | input | 2 | Access selector: bit 1 instruction, bit 0 data |
| ent_valid | input | 1 | Entry strobe during a write |
| ent_data | input | 16 | Entry being written |
| done | output | 1 | One-cycle end-of-command pulse |
| ok | output | 1 | Status qualified by done: 1 success, 0 invalid argument |
| rd_valid | output | 1 | Read beat valid |
| rd_data | output | 16 | Read beat entry |
| lst_priv | input | 1 | Probe read port: mode select |
| lst_instr | input | 1 | Probe read port: 1 instruction list, 0 data list |
| lst_idx | input | $clog2(ENTRIES) | Probe read port: entry index |
| lst_entry | output | 16 | Probe read port: live entry |

## Verification
The hardest case to reach is a write that fails only on an entry late in the stream, after earlier entries have already landed in the shadow buffer. It must leave the live lists untouched. A related case is an illegal entry placed just after the terminator, which must not cause a reject.

Directed writes put a bad size or context in the last slot, and a bad entry right after a cleared enable. Random writes vary the terminator position, the capability mask, the shared-context count and the unified flags on every command. After every write, the bench reads all four lists through the probe port and compares them with its model.

// File: rtl/srch_cfg_check.sv
module srch_cfg_check #(
  parameter int ENTRIES = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [7:0]                 size_mask,
  input  logic [3:0]                 shared_cnt,
  input  logic                       uni_priv,
  input  logic                       uni_user,
  input  logic                       cmd_valid,
  input  logic                       cmd_set,
  input  logic                       cmd_priv,
  input  logic [1:0]                 cmd_flags,
  input  logic                       ent_valid,
  input  logic [15:0]                ent_data,
  output logic                       done,
  output logic                       ok,
  output logic                       rd_valid,
  output logic [15:0]                rd_data,
  input  logic                       lst_priv,
  input  logic                       lst_instr,
  input  logic [$clog2(ENTRIES)-1:0] lst_idx,
  output logic [15:0]                lst_entry
);
  localparam int IW = $clog2(ENTRIES);
  localparam int LW = 16 * ENTRIES * 4;

  typedef enum logic [1:0] {IDLE, LOAD, READ} st_t;

  st_t         st;
  logic [IW-1:0] cnt;
  logic        set_q, priv_q, term_q, bad_q;
  logic [1:0]  flags_q;
  logic [15:0] shadow [ENTRIES];
  logic [LW-1:0] live_q;

  wire       uni     = priv_q ? uni_priv : uni_user;
  wire       ent_en  = ent_data[15];
  wire [3:0] ent_ctx = ent_data[10:7];
  wire [2:0] ent_sz  = ent_data[2:0];
  wire       ent_bad = !term_q && ent_en &&
                       (!size_mask[ent_sz] || (ent_ctx > shared_cnt) || (priv_q && ent_ctx != 4'd0));
  wire       last    = (cnt == IW'(ENTRIES - 1));
  wire       flags_bad = (flags_q == 2'b00) || (uni && flags_q != 2'b11);
  wire       set_ok  = !bad_q && !ent_bad && !flags_bad;
  wire [1:0] rd_sel  = {priv_q, flags_q[1]};

  assign lst_entry = live_q[16 * (int'({lst_priv, lst_instr}) * ENTRIES + int'(lst_idx)) +: 16];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= IDLE;
      cnt      <= '0;
      set_q    <= 1'b0;
      priv_q   <= 1'b0;
      flags_q  <= 2'b00;
      term_q   <= 1'b0;
      bad_q    <= 1'b0;
      done     <= 1'b0;
      ok       <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      live_q   <= '0;
      for (int k = 0; k < ENTRIES; k++) shadow[k] <= '0;
    end else begin
      done     <= 1'b0;
      rd_valid <= 1'b0;
      case (st)
        IDLE: if (cmd_valid) begin
          set_q   <= cmd_set;
          priv_q  <= cmd_priv;
          flags_q <= cmd_flags;
          cnt     <= '0;
          term_q  <= 1'b0;
          bad_q   <= 1'b0;
          if (cmd_set) st <= LOAD;
          else if (cmd_flags == 2'b00 || cmd_flags == 2'b11) begin
            done <= 1'b1;
            ok   <= 1'b0;
          end else st <= READ;
        end
        LOAD: if (ent_valid) begin
          shadow[cnt] <= ent_data;
          if (!ent_en) term_q <= 1'b1;
          if (ent_bad) bad_q <= 1'b1;
          cnt <= cnt + 1'b1;
          if (last) begin
            st   <= IDLE;
            cnt  <= '0;
            done <= 1'b1;
            ok   <= set_ok;
            if (set_ok)
              for (int l = 0; l < 2; l++)
                if (flags_q[l])
                  for (int k = 0; k < ENTRIES; k++)
                    live_q[16 * ((int'(priv_q) * 2 + l) * ENTRIES + k) +: 16] <=
                      (IW'(k) == cnt) ? ent_data : shadow[k];
          end
        end
        READ: begin
          rd_valid <= 1'b1;
          rd_data  <= live_q[16 * (int'(rd_sel) * ENTRIES + int'(cnt)) +: 16];
          cnt      <= cnt + 1'b1;
          if (last) begin
            st   <= IDLE;
            cnt  <= '0;
            done <= 1'b1;
            ok   <= 1'b1;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/srch_cfg_check_sva.sv
module srch_cfg_check_sva #(
  parameter int ENTRIES = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    done,
  input logic                    ok,
  input logic                    rd_valid,
  input logic                    set_q,
  input logic                    priv_q,
  input logic [1:0]              flags_q,
  input logic                    uni_priv,
  input logic                    uni_user,
  input logic [16*ENTRIES*4-1:0] live_q
);
  a_r2_zero_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (done && flags_q == 2'b00) |-> !ok);

  a_r3_read_both: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !set_q && flags_q == 2'b11) |-> !ok);

  a_r3_read_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $stable(live_q));

  a_r4_unified_both: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ok && set_q && (priv_q ? uni_priv : uni_user)) |-> flags_q == 2'b11);

  a_r9_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ok) |-> $stable(live_q));
endmodule

bind srch_cfg_check srch_cfg_check_sva #(.ENTRIES(ENTRIES)) u_sva (
  .clk(clk), .rst_n(rst_n), .done(done), .ok(ok), .rd_valid(rd_valid),
  .set_q(set_q), .priv_q(priv_q), .flags_q(flags_q),
  .uni_priv(uni_priv), .uni_user(uni_user), .live_q(live_q)
);

// File: tb/srch_cfg_check_tb.sv
`timescale 1ns/1ps
module srch_cfg_check_tb;
  localparam int ENTRIES = 8;
  localparam int IW = $clog2(ENTRIES);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] size_mask = 8'hFF;
  logic [3:0] shared_cnt = 4'd2;
  logic uni_priv = 1'b0, uni_user = 1'b0;
  logic cmd_valid = 1'b0, cmd_set = 1'b0, cmd_priv = 1'b0;
  logic [1:0] cmd_flags = 2'b00;
  logic ent_valid = 1'b0;
  logic [15:0] ent_data = '0;
  logic done, ok, rd_valid;
  logic [15:0] rd_data;
  logic lst_priv = 1'b0, lst_instr = 1'b0;
  logic [IW-1:0] lst_idx = '0;
  logic [15:0] lst_entry;

  always #2.5 clk = ~clk;

  srch_cfg_check #(.ENTRIES(ENTRIES)) u_dut (
    .clk(clk), .rst_n(rst_n), .size_mask(size_mask), .shared_cnt(shared_cnt),
    .uni_priv(uni_priv), .uni_user(uni_user), .cmd_valid(cmd_valid), .cmd_set(cmd_set),
    .cmd_priv(cmd_priv), .cmd_flags(cmd_flags), .ent_valid(ent_valid), .ent_data(ent_data),
    .done(done), .ok(ok), .rd_valid(rd_valid), .rd_data(rd_data),
    .lst_priv(lst_priv), .lst_instr(lst_instr), .lst_idx(lst_idx), .lst_entry(lst_entry)
  );

  int tests = 0, fails = 0;
  logic [15:0] ents [ENTRIES];
  logic [15:0] model [4][ENTRIES];

  task automatic chk(input bit pass, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!pass) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_set(input bit pr, input logic [1:0] fl);
    bit uni = pr ? uni_priv : uni_user;
    if (fl == 2'b00) return 1'b0;
    if (uni && fl != 2'b11) return 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!ents[i][15]) return 1'b1;
      if (!size_mask[ents[i][2:0]]) return 1'b0;
      if (ents[i][10:7] > shared_cnt) return 1'b0;
      if (pr && ents[i][10:7] != 4'd0) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic cmp_lists(input string req);
    int bad = 0;
    logic [15:0] first_act = '0, first_exp = '0;
    for (int s = 0; s < 4; s++)
      for (int i = 0; i < ENTRIES; i++) begin
        lst_priv = s[1]; lst_instr = s[0]; lst_idx = IW'(i);
        #0.1;
        if (lst_entry !== model[s][i]) begin
          if (bad == 0) begin first_act = lst_entry; first_exp = model[s][i]; end
          bad++;
        end
      end
    chk(bad == 0, req, 32'(first_act), 32'(first_exp));
  endtask

  task automatic do_set(input bit pr, input logic [1:0] fl, input string req);
    bit e = exp_set(pr, fl);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_set = 1'b1; cmd_priv = pr; cmd_flags = fl;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      ent_valid = 1'b1; ent_data = ents[i];
      @(negedge clk);
      if (i < ENTRIES - 1) chk(!done, "R10 early done", 32'(done), 0);
    end
    ent_valid = 1'b0;
    chk(done === 1'b1, "R10 done timing", 32'(done), 1);
    chk(ok === e, req, 32'(ok), 32'(e));
    if (e)
      for (int l = 0; l < 2; l++)
        if (fl[l]) for (int i = 0; i < ENTRIES; i++) model[int'(pr) * 2 + l][i] = ents[i];
    cmp_lists({req, " R9 lists"});
  endtask

  task automatic do_get(input bit pr, input logic [1:0] fl, input string req);
    bit e = (fl == 2'b01 || fl == 2'b10);
    int beats = 0, bad = 0, sel = int'(pr) * 2 + int'(fl[1]);
    bit seen = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_set = 1'b0; cmd_priv = pr; cmd_flags = fl;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int c = 0; c < ENTRIES + 4 && !seen; c++) begin
      if (rd_valid) begin
        if (beats < ENTRIES && rd_data !== model[sel][beats]) bad++;
        beats++;
      end
      if (done) seen = 1'b1;
      else @(negedge clk);
    end
    chk(seen && ok === e, req, 32'(ok), 32'(e));
    chk(beats == (e ? ENTRIES : 0), {req, " R3 beats"}, 32'(beats), e ? ENTRIES : 0);
    chk(bad == 0, {req, " R3 data"}, 32'(bad), 0);
    cmp_lists({req, " R3 unchanged"});
  endtask

  task automatic fill(input logic [15:0] v);
    for (int i = 0; i < ENTRIES; i++) ents[i] = v;
  endtask

  function automatic logic [15:0] mk(input bit en, input int ctx, input int sz);
    return {en, 4'b0000, 4'(ctx), 4'b0000, 3'(sz)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int s = 0; s < 4; s++) for (int i = 0; i < ENTRIES; i++) model[s][i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !rd_valid, "R1 outputs idle", 32'({done, rd_valid}), 0);
    cmp_lists("R1 lists zero");

    for (int i = 0; i < ENTRIES; i++) ents[i] = mk(1, i % 3, i % 8);
    do_set(0, 2'b11, "R9 user both");
    do_set(0, 2'b00, "R2 set flags zero");
    do_get(0, 2'b00, "R2 get flags zero");
    do_get(0, 2'b11, "R3 get both");
    do_get(0, 2'b10, "R3 get instr");
    fill(mk(1, 1, 5));
    do_set(0, 2'b01, "R9 user data only");
    do_get(0, 2'b01, "R3 get data");

    uni_user = 1'b1;
    fill(mk(1, 0, 2));
    do_set(0, 2'b10, "R4 unified single");
    do_set(0, 2'b11, "R4 unified both");
    uni_user = 1'b0;

    size_mask = 8'hEF;
    fill(mk(1, 0, 1)); ents[ENTRIES-1] = mk(1, 0, 4);
    do_set(0, 2'b11, "R5 size missing last");
    size_mask = 8'hFF;

    fill(mk(1, 2, 0)); ents[ENTRIES-1] = mk(1, 3, 0);
    do_set(0, 2'b10, "R6 ctx above count");
    shared_cnt = 4'd0;
    fill(mk(1, 0, 0)); ents[3] = mk(1, 1, 0);
    do_set(0, 2'b10, "R6 ctx with none");
    shared_cnt = 4'd3;
    fill(mk(1, 0, 3)); ents[5] = mk(1, 1, 3);
    do_set(1, 2'b11, "R7 priv ctx");
    fill(mk(1, 0, 3));
    do_set(1, 2'b11, "R7 priv ctx zero");

    size_mask = 8'h0F;
    fill(mk(1, 0, 1)); ents[2] = mk(0, 9, 7); ents[3] = mk(1, 15, 6);
    do_set(1, 2'b10, "R8 after terminator");
    do_get(1, 2'b10, "R8 stored as given");
    size_mask = 8'hFF;

    void'($urandom(32'd20240611));
    for (int n = 0; n < 300; n++) begin
      bit pr = $urandom % 2;
      logic [1:0] fl = 2'($urandom);
      size_mask  = 8'($urandom | $urandom);
      shared_cnt = 4'($urandom % 3);
      uni_priv   = ($urandom % 4) == 0;
      uni_user   = ($urandom % 4) == 0;
      for (int i = 0; i < ENTRIES; i++)
        ents[i] = {($urandom % 6) != 0, 4'($urandom), 4'($urandom % 4), 4'($urandom), 3'($urandom)};
      if ($urandom % 3 == 0) do_get(pr, fl, "R3 random get");
      else do_set(pr, fl, "R9 random set");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule